// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block holds the digital timing of a dual-slope integrating converter. A divide-by-four prescaler turns the oscillator into count ticks. Two decade (BCD) counters run on those ticks. A small state machine drives three mutually exclusive phase enables: auto-zero, signal integrate and reference de-integrate. The analog integrator, the reference switches and the comparator sit outside the block. The block sees only the comparator's zero-crossing output, and it drives only the switch enables.

Integration always lasts a fixed window. De-integration runs until the comparator reports the crossing, up to a ceiling. Auto-zero takes whatever is left of a fixed cycle, so conversions arrive at a constant rate for any input. When de-integration ends, the block latches the number of counts it lasted as a BCD result and pulses a valid strobe for one clock. If no crossing arrives before the ceiling, it sets an overrange flag.

Top module: `dsadc_seq`

## Requirements
- R1: One count equals four oscillator clocks, so every phase lasts a whole number of counts times four clocks.
- R2: The integrate phase lasts exactly 1000 counts (4000 clocks).
- R3: De-integrate ends on the first count tick at which `cmp_zero` is sampled high. It then has lasted m counts, where m is from 1 to 2000. `cmp_zero` has no effect during auto-zero or integrate.
- R4: Auto-zero takes the remainder of the cycle. From one integrate start to the next is always 4000 counts (16000 clocks).
- R5: If no crossing is seen in 2000 counts, de-integrate ends after 2000 counts. The result is then BCD 2000 and `rslt_ovr` is 1. A crossing on the 2000th count gives 2000 with `rslt_ovr` 0.
- R6: `rslt_bcd` holds the de-integrate length m as four BCD digits. Digit k sits in bits [4k+3:4k], with the units digit in bits [3:0].
- R7: `rslt_valid` is high for exactly one clock, on the clock at which de-integrate gives way to auto-zero. `rslt_bcd` and `rslt_ovr` change only then and hold their values until the next strobe.
- R8: After reset the phases run auto-zero (1000 counts), then integrate, then de-integrate, then auto-zero, and repeat.
- R9: Exactly one of `ph_az`, `ph_int` and `ph_deint` is high in every clock out of reset.
- R10: A synchronous active-low reset selects auto-zero and clears `rslt_bcd`, `rslt_ovr` and `rslt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_zero | input | 1 | Comparator reports integrator zero crossing |
| ph_az | output | 1 | Auto-zero phase enable |
| ph_int | output | 1 | Signal-integrate phase enable |
| ph_deint | output | 1 | Reference de-integrate phase enable |
| rslt_bcd | output | 16 | Latched result, four BCD digits |
| rslt_ovr | output | 1 | Latched overrange flag |
| rslt_valid | output | 1 | One-clock strobe when a new result is latched |

## Verification
A wrong prescaler or a wrong cycle counter shows up within one conversion, about 16000 clocks. Integrate or auto-zero then has the wrong length, or the start-to-start period moves away from 16000 clocks. A fault in the de-integrate counter or in the result capture shows up on the first strobe, as a wrong BCD value, a wrong overrange flag or a strobe that comes too early or too late. A phase machine that leaks or drops an enable breaks the one-hot rule on the clock where it happens. One that reacts to the comparator outside de-integrate shortens integrate or strobes during it, within the same conversion.

// File: rtl/dsadc_pkg.sv
// Package: shared phase encoding and a constant BCD converter.
// Assumes values passed to to_bcd fit in eight decimal digits.
package dsadc_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_t;

    // Turn a binary constant into packed BCD, units digit in the low nibble.
    function automatic logic [31:0] to_bcd(input int unsigned value);
        logic [31:0] r;
        int unsigned t;
        r = '0;
        t = value;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dsadc_prescaler.sv
// Module: divides the oscillator into one-clock count ticks.
// Assumes DIV >= 2; tick is high on every DIV-th clock after reset.
module dsadc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + CW'(1);
    end

    assign tick = (div_q == LAST);

    // Ticks never come on two clocks in a row (R1).
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // The divider state never passes its last value (R1).
    assert_div_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);

endmodule

// File: rtl/dsadc_bcd_counter.sv
// Module: multi-digit decade counter with load and increment.
// Assumes load values are valid BCD; it wraps from all nines to zero.
module dsadc_bcd_counter #(
    parameter int                    DIGITS  = 4,
    parameter logic [DIGITS*4-1:0]   RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld,
    input  logic [DIGITS*4-1:0]   ld_val,
    input  logic                  inc,
    output logic [DIGITS*4-1:0]   q
);
    localparam int W = DIGITS * 4;

    logic [W-1:0]      q_next;
    logic [DIGITS-1:0] carry;

    assign carry[0] = 1'b1;

    // Ripple carry: a digit advances when every lower digit is nine.
    for (genvar g = 1; g < DIGITS; g++) begin : g_carry
        assign carry[g] = carry[g-1] && (q[4*(g-1) +: 4] == 4'd9);
    end

    // Per-digit decade step.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign q_next[4*g +: 4] = !carry[g]                 ? q[4*g +: 4] :
                                  (q[4*g +: 4] == 4'd9)     ? 4'd0        :
                                                              4'(q[4*g +: 4] + 4'd1);

        // Every digit stays a decimal digit (R6).
        assert_digit_bcd_R6: assert property (@(posedge clk) disable iff (!rst_n)
            q[4*g +: 4] <= 4'd9);
    end

    // Load has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q_next;
    end

endmodule

// File: rtl/dsadc_phase_ctrl.sv
// Module: phase state machine and result capture.
// Assumes cyc_q counts ticks through the conversion cycle and dcnt_q
// counts de-integrate ticks starting from one; both are BCD.
module dsadc_phase_ctrl
    import dsadc_pkg::*;
#(
    parameter int DIGITS       = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cmp_zero,
    input  logic [DIGITS*4-1:0] cyc_q,
    input  logic [DIGITS*4-1:0] dcnt_q,
    output logic                cyc_ld,
    output logic                cyc_inc,
    output logic                dcnt_ld,
    output logic                dcnt_inc,
    output logic                ph_az,
    output logic                ph_int,
    output logic                ph_deint,
    output logic [DIGITS*4-1:0] rslt_bcd,
    output logic                rslt_ovr,
    output logic                rslt_valid
);
    localparam int W = DIGITS * 4;
    localparam logic [31:0] CYC_LAST_F = to_bcd(CYCLE_COUNTS - 1);
    localparam logic [31:0] INT_LAST_F = to_bcd(INT_COUNTS - 1);
    localparam logic [31:0] INT_CNT_F  = to_bcd(INT_COUNTS);
    localparam logic [31:0] DMAX_F     = to_bcd(DEINT_MAX);

    phase_t state_q, state_d;
    logic   cyc_last, int_last, deint_full, deint_done;

    // Decode where the counters stand.
    always_comb begin
        cyc_last   = (cyc_q  == CYC_LAST_F[W-1:0]);
        int_last   = (cyc_q  == INT_LAST_F[W-1:0]);
        deint_full = (dcnt_q == DMAX_F[W-1:0]);
        deint_done = tick && (state_q == PH_DEINT) && (cmp_zero || deint_full);
    end

    // Next phase, advanced only on count ticks.
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                PH_AZ:    if (cyc_last)   state_d = PH_INT;
                PH_INT:   if (int_last)   state_d = PH_DEINT;
                PH_DEINT: if (deint_done) state_d = PH_AZ;
                default:                  state_d = PH_AZ;
            endcase
        end
    end

    // Counter controls: the cycle counter wraps at the end of auto-zero,
    // the de-integrate counter is preset to one as de-integrate starts.
    always_comb begin
        cyc_ld   = tick && (state_q == PH_AZ) && cyc_last;
        cyc_inc  = tick;
        dcnt_ld  = tick && (state_q == PH_INT) && int_last;
        dcnt_inc = tick && (state_q == PH_DEINT);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_AZ;
        else        state_q <= state_d;
    end

    // Result capture and one-clock strobe at the end of de-integrate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rslt_bcd   <= '0;
            rslt_ovr   <= 1'b0;
            rslt_valid <= 1'b0;
        end else begin
            rslt_valid <= deint_done;
            if (deint_done) begin
                rslt_bcd <= dcnt_q;
                rslt_ovr <= !cmp_zero;
            end
        end
    end

    assign ph_az    = (state_q == PH_AZ);
    assign ph_int   = (state_q == PH_INT);
    assign ph_deint = (state_q == PH_DEINT);

    // Exactly one enable at a time (R9).
    assert_phase_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({ph_az, ph_int, ph_deint}));

    // Integrate always opens on a cycle counter at zero (R4).
    assert_int_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_int) |-> (cyc_q == '0));

    // De-integrate opens after the full integrate window (R2).
    assert_deint_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_deint) |-> (cyc_q == INT_CNT_F[W-1:0]) && (dcnt_q == W'(1)));

    // De-integrate never runs past its ceiling (R5).
    assert_deint_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ph_deint |-> (dcnt_q <= DMAX_F[W-1:0]));

    // The strobe lasts one clock (R7).
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |=> !rslt_valid);

    // The strobe comes only as de-integrate hands over to auto-zero (R7).
    assert_valid_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> ph_az && $past(ph_deint));

    // Overrange always reports the ceiling value (R5).
    assert_ovr_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rslt_valid && rslt_ovr) |-> (rslt_bcd == DMAX_F[W-1:0]));

    // Between strobes the result holds (R7).
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rslt_valid |-> $stable(rslt_bcd) && $stable(rslt_ovr));

endmodule

// File: rtl/dsadc_seq.sv
// Module: top of the dual-slope phase sequencer.
// Assumes a synchronous active-low reset and a comparator output that is
// already synchronous to clk. The first auto-zero after reset lasts
// INT_COUNTS; later ones take the rest of the CYCLE_COUNTS cycle.
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int PRESCALE     = 4,
    parameter int DIGITS       = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmp_zero,
    output logic                 ph_az,
    output logic                 ph_int,
    output logic                 ph_deint,
    output logic [DIGITS*4-1:0]  rslt_bcd,
    output logic                 rslt_ovr,
    output logic                 rslt_valid
);
    localparam int W = DIGITS * 4;
    localparam logic [31:0] CYC_RST_F = to_bcd(CYCLE_COUNTS - INT_COUNTS);

    logic         tick;
    logic [W-1:0] cyc_q, dcnt_q;
    logic         cyc_ld, cyc_inc, dcnt_ld, dcnt_inc;

    dsadc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dsadc_bcd_counter #(.DIGITS(DIGITS), .RST_VAL(CYC_RST_F[W-1:0])) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cyc_ld),
        .ld_val ('0),
        .inc    (cyc_inc),
        .q      (cyc_q)
    );

    dsadc_bcd_counter #(.DIGITS(DIGITS), .RST_VAL('0)) u_dcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (dcnt_ld),
        .ld_val (W'(1)),
        .inc    (dcnt_inc),
        .q      (dcnt_q)
    );

    dsadc_phase_ctrl #(
        .DIGITS       (DIGITS),
        .INT_COUNTS   (INT_COUNTS),
        .DEINT_MAX    (DEINT_MAX),
        .CYCLE_COUNTS (CYCLE_COUNTS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmp_zero   (cmp_zero),
        .cyc_q      (cyc_q),
        .dcnt_q     (dcnt_q),
        .cyc_ld     (cyc_ld),
        .cyc_inc    (cyc_inc),
        .dcnt_ld    (dcnt_ld),
        .dcnt_inc   (dcnt_inc),
        .ph_az      (ph_az),
        .ph_int     (ph_int),
        .ph_deint   (ph_deint),
        .rslt_bcd   (rslt_bcd),
        .rslt_ovr   (rslt_ovr),
        .rslt_valid (rslt_valid)
    );

endmodule

// File: tb/dsadc_seq_tb.sv
// Bench: walks a table of de-integrate lengths through full conversions,
// then checks a reset taken in the middle of de-integrate.
module dsadc_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_zero = 1'b0;
    logic        ph_az, ph_int, ph_deint;
    logic [15:0] rslt_bcd;
    logic        rslt_ovr, rslt_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int onehot_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dsadc_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_zero   (cmp_zero),
        .ph_az      (ph_az),
        .ph_int     (ph_int),
        .ph_deint   (ph_deint),
        .rslt_bcd   (rslt_bcd),
        .rslt_ovr   (rslt_ovr),
        .rslt_valid (rslt_valid)
    );

    // Vector table: m = crossing count (0 = none), pre-high comparator,
    // expected BCD result and overrange flag.
    localparam int          NV = 6;
    localparam int          VEC_M   [NV] = '{1, 7, 1234, 0, 2000, 250};
    localparam bit          VEC_PRE [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [15:0] VEC_RES [NV] = '{16'h0001, 16'h0007, 16'h1234,
                                            16'h2000, 16'h2000, 16'h0250};
    localparam bit          VEC_OVR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One-hot monitor on phase enables (R9).
    always @(negedge clk) begin
        if (rst_n && !done && ($countones({ph_az, ph_int, ph_deint}) != 1))
            onehot_bad++;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_int, n_de, n_az, md;
        bit seen;
        repeat (3) @(negedge clk);
        // R10: state during reset.
        chk("R10", "ph_az in reset", ph_az, 1);
        chk("R10", "ph_int/ph_deint in reset", {ph_int, ph_deint}, 0);
        chk("R10", "valid/ovr in reset", {rslt_valid, rslt_ovr}, 0);
        chk("R10", "result in reset", rslt_bcd, 0);
        rst_n = 1'b1;

        // R8: first auto-zero lasts 1000 counts.
        n_az = 0;
        while (ph_az) begin n_az++; @(negedge clk); end
        chk("R8", "first auto-zero clocks", n_az, 4000);
        chk("R8", "integrate follows auto-zero", ph_int, 1);

        for (int v = 0; v < NV; v++) begin
            md = (VEC_M[v] == 0) ? 2000 : VEC_M[v];
            if (VEC_PRE[v]) cmp_zero = 1'b1;
            n_int = 0;
            seen = 1'b0;
            while (ph_int) begin
                if (rslt_valid) seen = 1'b1;
                n_int++;
                @(negedge clk);
            end
            chk("R1 R2", "integrate clocks", n_int, 4000);
            chk("R3", "no strobe while comparator high in integrate", seen, 0);
            chk("R8", "de-integrate follows integrate", ph_deint, 1);

            n_de = 0;
            while (!rslt_valid) begin
                if (!VEC_PRE[v] && VEC_M[v] > 0 && n_de == 4 * (VEC_M[v] - 1))
                    cmp_zero = 1'b1;
                n_de++;
                @(negedge clk);
            end
            chk("R3 R5", "de-integrate clocks", n_de, 4 * md);
            chk("R6", "result BCD", rslt_bcd, VEC_RES[v]);
            chk("R5", "overrange flag", rslt_ovr, VEC_OVR[v]);
            chk("R7", "auto-zero at strobe", {ph_az, ph_deint}, 2'b10);
            cmp_zero = 1'b0;
            @(negedge clk);
            chk("R7", "strobe width", rslt_valid, 0);

            n_az = 1;
            while (ph_az) begin n_az++; @(negedge clk); end
            chk("R4", "auto-zero clocks", n_az, 16000 - 4000 - 4 * md);
            chk("R4", "cycle clocks", n_int + n_de + n_az, 16000);
            chk("R7", "result held", rslt_bcd, VEC_RES[v]);
        end

        // R10: reset in the middle of de-integrate.
        while (!ph_deint) @(negedge clk);
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "auto-zero after mid-run reset", {ph_az, ph_int, ph_deint}, 3'b100);
        chk("R10", "result cleared", {rslt_bcd, rslt_ovr, rslt_valid}, 0);
        rst_n = 1'b1;
        n_az = 0;
        while (ph_az) begin n_az++; @(negedge clk); end
        chk("R8", "auto-zero after mid-run reset", n_az, 4000);

        chk("R9", "one-hot violations", onehot_bad, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule